// File: doc/BRIEF.md
# Eight-Bit Flagged Arithmetic Logic Unit

This block is the arithmetic and logic datapath of a small accumulator-style processor. Each cycle the processor presents a 4-bit operation code, two 8-bit operands `a` and `b`, and a carry input. The unit computes an 8-bit result and four status bits: zero, sign, carry-out and overflow. The result and the status bits are captured on the falling edge of the processor clock. A value driven just after a rising edge can therefore be read at the following rising edge.

Twelve operations are supported. Each group uses the carry input and drives the carry and overflow outputs in its own way. Operation codes:

| Code | Operation |
|------|-----------|
| 0 | add |
| 1 | subtract |
| 2 | increment |
| 3 | decrement |
| 4 | AND |
| 5 | OR |
| 6 | XOR |
| 7 | NOT |
| 8 | shift left |
| 9 | shift right |
| 10 | rotate left |
| 11 | rotate right |

Codes 12 through 15 are unassigned.

Decoding instructions, choosing registers and holding the flags are the processor's job. This unit only computes.

Top module: `flag_alu`

## Requirements
- R1: Add (code 0) gives y = (a + b + cin) mod 256. cout is the carry out of bit 7. ovf is 1 when the signed sum of a, b and cin lies outside -128..127.
- R2: Subtract (code 1) gives y = (a - b - cin) mod 256. cout is 1 when a - b - cin is negative, which is a borrow. ovf is 1 when the signed difference lies outside -128..127.
- R3: Increment (code 2) gives y = (a + 1) mod 256, and decrement (code 3) gives y = (a - 1) mod 256. Both ignore b and cin, and both drive cout and ovf to 0.
- R4: Code 4 gives a AND b, code 5 gives a OR b, and code 6 gives a XOR b. Code 7 gives NOT a and ignores b. All four ignore cin and drive cout and ovf to 0.
- R5: Shift left (code 8) gives {a[6:0], 0}. It ignores cin and drives cout and ovf to 0.
- R6: Shift right (code 9) and rotate right (code 11) both give {cin, a[7:1]} with cout = a[0] and ovf = 0.
- R7: Rotate left (code 10) gives {a[6:0], cin} with cout = a[7] and ovf = 0.
- R8: For every assigned code, zero is 1 exactly when y is 0, and sign equals y[7].
- R9: Codes 12 to 15 give y = 0 with zero, sign, cout and ovf all 0.
- R10: Inputs are sampled on the falling clock edge. The outputs change only at a falling edge, and input changes made between a falling edge and the next rising edge do not reach the outputs before the next falling edge.
- R11: A synchronous active-high reset, sampled on the falling edge, clears y and all four flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; outputs update on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| a | input | 8 | First operand; the only source for single-operand codes |
| b | input | 8 | Second operand |
| cin | input | 1 | Carry input |
| y | output | 8 | Registered result |
| zero | output | 1 | Result-is-zero flag |
| sign | output | 1 | Copy of result bit 7 |
| cout | output | 1 | Carry or borrow out, or the bit shifted out |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The assertions check the following on every falling edge:
- Reset clears the outputs.
- Unassigned codes give an all-zero output.
- The zero and sign flags agree with the registered result.
- Overflow stays low outside add and subtract.
- Carry stays low for operations that cannot produce one.

The arithmetic values themselves can only be shown by the bench's sweeps. These are:
- the 8-bit sums and borrows;
- signed overflow at the ±128 boundary;
- the bits moved in by the shifts and rotates;
- the claim that inputs changed after a falling edge do not reach the outputs early.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_INC = 4'd2,
    OP_DEC = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_NOT = 4'd7,
    OP_SHL = 4'd8,
    OP_SHR = 4'd9,
    OP_ROL = 4'd10,
    OP_ROR = 4'd11
  } alu_op_e;

  localparam logic [OP_W-1:0] FIRST_UNASSIGNED = 4'd12;
endpackage

// File: rtl/flag_alu_arith.sv
module flag_alu_arith
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] y,
  output logic             cout,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] sum_ext;
  logic [WIDTH:0] diff_ext;
  logic [WIDTH:0] cin_ext;

  assign cin_ext  = {{WIDTH{1'b0}}, cin};
  assign sum_ext  = {1'b0, a} + {1'b0, b} + cin_ext;
  assign diff_ext = {1'b0, a} - {1'b0, b} - cin_ext;

  always_comb begin
    y    = '0;
    cout = 1'b0;
    ovf  = 1'b0;
    case (op)
      OP_ADD: begin
        y    = sum_ext[MSB:0];
        cout = sum_ext[WIDTH];
        ovf  = (a[MSB] == b[MSB]) && (sum_ext[MSB] != a[MSB]);
      end
      OP_SUB: begin
        y    = diff_ext[MSB:0];
        cout = diff_ext[WIDTH];
        ovf  = (a[MSB] != b[MSB]) && (diff_ext[MSB] != a[MSB]);
      end
      OP_INC:  y = a + {{(WIDTH-1){1'b0}}, 1'b1};
      OP_DEC:  y = a - {{(WIDTH-1){1'b0}}, 1'b1};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOT:  y = ~a;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/flag_alu_shift.sv
module flag_alu_shift
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic             cin,
  output logic [WIDTH-1:0] y,
  output logic             cout
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] up_fill0;
  logic [WIDTH-1:0] up_fillc;
  logic [WIDTH-1:0] dn_fillc;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bits
    if (i == 0) begin : g_low
      assign up_fill0[i] = 1'b0;
      assign up_fillc[i] = cin;
    end else begin : g_up
      assign up_fill0[i] = a[i-1];
      assign up_fillc[i] = a[i-1];
    end
    if (i == MSB) begin : g_high
      assign dn_fillc[i] = cin;
    end else begin : g_dn
      assign dn_fillc[i] = a[i+1];
    end
  end

  always_comb begin
    y    = '0;
    cout = 1'b0;
    case (op)
      OP_SHL: y = up_fill0;
      OP_SHR, OP_ROR: begin
        y    = dn_fillc;
        cout = a[0];
      end
      OP_ROL: begin
        y    = up_fillc;
        cout = a[MSB];
      end
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] y,
  output logic             zero,
  output logic             sign,
  output logic             cout,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  alu_op_e op_e;
  assign op_e = alu_op_e'(op);

  logic [WIDTH-1:0] ar_y, lg_y, sh_y;
  logic             ar_c, ar_v, sh_c;

  flag_alu_arith #(.WIDTH(WIDTH)) u_arith (
    .op(op_e), .a(a), .b(b), .cin(cin), .y(ar_y), .cout(ar_c), .ovf(ar_v)
  );

  flag_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .op(op_e), .a(a), .b(b), .y(lg_y)
  );

  flag_alu_shift #(.WIDTH(WIDTH)) u_shift (
    .op(op_e), .a(a), .cin(cin), .y(sh_y), .cout(sh_c)
  );

  logic [WIDTH-1:0] res;
  logic             res_c, res_v, legal;

  always_comb begin
    res   = '0;
    res_c = 1'b0;
    res_v = 1'b0;
    legal = 1'b1;
    case (op_e)
      OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
        res   = ar_y;
        res_c = ar_c;
        res_v = ar_v;
      end
      OP_AND, OP_OR, OP_XOR, OP_NOT: res = lg_y;
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        res   = sh_y;
        res_c = sh_c;
      end
      default: legal = 1'b0;
    endcase
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      y    <= '0;
      zero <= 1'b0;
      sign <= 1'b0;
      cout <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      y    <= res;
      zero <= legal && (res == '0);
      sign <= legal && res[MSB];
      cout <= res_c;
      ovf  <= res_v;
    end
  end

  AST_RESET_CLEARS: assert property (@(negedge clk)
    rst |=> (y == '0) && !zero && !sign && !cout && !ovf); // R11

  AST_UNASSIGNED_ZERO: assert property (@(negedge clk) disable iff (rst)
    (op >= FIRST_UNASSIGNED) |=> (y == '0) && !zero && !sign && !cout && !ovf); // R9

  AST_ZERO_FLAG: assert property (@(negedge clk) disable iff (rst)
    (op < FIRST_UNASSIGNED) |=> (zero == (y == '0))); // R8

  AST_SIGN_FLAG: assert property (@(negedge clk) disable iff (rst)
    (op < FIRST_UNASSIGNED) |=> (sign == y[MSB])); // R8

  AST_NO_OVERFLOW: assert property (@(negedge clk) disable iff (rst)
    (op != 4'd0 && op != 4'd1) |=> !ovf); // R3

  AST_NO_CARRY: assert property (@(negedge clk) disable iff (rst)
    (op >= 4'd2 && op <= 4'd8) |=> !cout); // R4
endmodule

// File: tb/flag_alu_bench.sv
module flag_alu_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op  = '0;
  logic [7:0] a   = '0;
  logic [7:0] b   = '0;
  logic       cin = 1'b0;
  logic [7:0] y;
  logic       zero, sign, cout, ovf;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  flag_alu u_flag_alu (
    .clk(clk), .rst(rst), .op(op), .a(a), .b(b), .cin(cin),
    .y(y), .zero(zero), .sign(sign), .cout(cout), .ovf(ovf)
  );

  always #5 clk = ~clk;

  function automatic string req_of(int code);
    case (code)
      0: return "R1";
      1: return "R2";
      2, 3: return "R3";
      4, 5, 6, 7: return "R4";
      8: return "R5";
      9, 11: return "R6";
      10: return "R7";
      default: return "R9";
    endcase
  endfunction

  // Expected output packed as {y, zero, sign, cout, ovf}
  function automatic logic [11:0] model(int code, int av, int bv, int c);
    int r, sa, sb, sr, yy, cy, vv, leg;
    sa = (av >= 128) ? av - 256 : av;
    sb = (bv >= 128) ? bv - 256 : bv;
    cy = 0; vv = 0; leg = 1; yy = 0;
    case (code)
      0: begin
        r = av + bv + c; yy = r % 256; cy = (r > 255);
        sr = sa + sb + c; vv = (sr > 127 || sr < -128);
      end
      1: begin
        r = av - bv - c; yy = (r + 512) % 256; cy = (r < 0);
        sr = sa - sb - c; vv = (sr > 127 || sr < -128);
      end
      2: yy = (av + 1) % 256;
      3: yy = (av + 255) % 256;
      4: yy = av & bv;
      5: yy = av | bv;
      6: yy = av ^ bv;
      7: yy = 255 - av;
      8: yy = (av * 2) % 256;
      9, 11: begin yy = av / 2 + c * 128; cy = av % 2; end
      10: begin yy = (av * 2) % 256 + c; cy = av / 128; end
      default: leg = 0;
    endcase
    return {yy[7:0], (leg == 1 && yy == 0), (leg == 1 && yy >= 128), cy[0], vv[0]};
  endfunction

  task automatic check(string req, logic [11:0] exp);
    vectors++;
    if ({y, zero, sign, cout, ovf} !== exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%0d b=%0d cin=%0d: got y=%0d z=%0b s=%0b c=%0b v=%0b, expected y=%0d z=%0b s=%0b c=%0b v=%0b",
               req, op, a, b, cin, y, zero, sign, cout, ovf,
               exp[11:4], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  // Drive after a rising edge, capture happens at the falling edge, check shortly after it.
  task automatic apply(int code, int av, int bv, int c);
    @(posedge clk); #1;
    op = code[3:0]; a = av[7:0]; b = bv[7:0]; cin = c[0];
    @(negedge clk); #1;
    check(req_of(code), model(code, av, bv, c));
  endtask

  initial begin
    #2000000;
    $display("FAIL watchdog: expected completion, simulation hung");
    fails++;
    vectors++;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [11:0] held;
    // R11: reset state
    op = 4'd7; a = 8'h00; cin = 1'b1;
    repeat (3) @(negedge clk);
    #1 check("R11", 12'h000);
    @(posedge clk); #1 rst = 1'b0;

    // Main sweep: all codes, every a, 16 spread b values, both carry inputs (R1-R9 by code, R8 flags)
    for (int code = 0; code < 16; code++)
      for (int c = 0; c < 2; c++)
        for (int k = 0; k < 16; k++)
          for (int av = 0; av < 256; av++)
            apply(code, av, (k == 15) ? 128 : k * 17, c);

    // Signed overflow boundaries (R1, R2)
    apply(0, 127, 0, 1);
    apply(0, 128, 255, 0);
    apply(1, 128, 0, 1);
    apply(1, 127, 255, 0);
    apply(1, 0, 0, 1);

    // R10: inputs changed after the falling edge stay invisible until the next falling edge
    apply(0, 10, 20, 0);
    held = model(0, 10, 20, 0);
    @(negedge clk); #2;
    op = 4'd7; a = 8'h00; b = 8'hff; cin = 1'b1;
    @(posedge clk); #1;
    check("R10", held);
    @(negedge clk); #1;
    check("R10", model(7, 0, 255, 1));

    // R11: reset applied mid-run clears a non-zero result
    apply(5, 255, 0, 0);
    @(posedge clk); #1 rst = 1'b1;
    @(negedge clk); #1 check("R11", 12'h000);
    @(posedge clk); #1 rst = 1'b0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule